// File: doc/BRIEF.md
# Scanned Key Matrix Encoder

This block reads a grid of plain push switches wired as 4 column lines by 4 or 5 row lines, with the row count set by a parameter. It pulls one column line low at a time, stepping to the next column on each pulse of a scan-step strobe. It watches the row lines, which float high when no switch is closed. When a row line reads low under the active column, scanning halts on that column. The block then follows only that row and times how long it stays low. If the row stays low for the whole debounce period, the block stores a binary key code and raises a data-valid flag.

The flag drops as soon as the held key lets go, even if another key is already down. Before any further closure can be taken, the released row must stay high for one full debounce period. This gives two-key roll-over: a second key pressed during the first is taken only after the first is lifted and that release time has passed. The stored code stays after release. It reaches a shared data bus through tri-state drivers enabled by an active-low enable.

Row inputs pass through a two-flop synchronizer. After each column step, two cycles must pass before a row may be sampled, so a low seen on a row always belongs to the column being driven.

Top module: `key_matrix_encoder`

## Requirements
- R1: Exactly one bit of `col_n` is low at any time. Bit k low selects column k. After reset column 0 is selected (`col_n` = 4'b1110). While scanning, each `scan_step` pulse moves the selection to the next column, in the order 0, 1, 2, 3, 0.
- R2: Once a row is seen low under the selected column, `col_n` holds its value until the key has been released and the release period has ended. Rows other than the captured one have no effect during that time.
- R3: The key code is row index × 4 + column index, both counted from zero. The column index fills code bits [1:0] and the row index fills the bits above. The code is 4 bits wide for 4 rows and 5 bits wide for 5 rows, so keys in row 4 read 16 to 19.
- R4: If several rows read low under the same column at once, the lowest-numbered row gives the code.
- R5: `dav` rises only after the captured row has stayed low for `DEBOUNCE_CYCLES` consecutive cycles. A closure that bounces high sooner restarts scanning and never raises `dav`.
- R6: `dav` falls within 3 cycles of the captured key opening, even while another key is held.
- R7: After a release, the row must stay high for `DEBOUNCE_CYCLES` cycles before scanning resumes. A second key held through the first key's press is then captured, debounced and reported.
- R8: The stored code stays unchanged after the key is released, until the next accepted key or a reset.
- R9: `key_bus` is high-impedance on every bit while `oe_n` is 1, and shows the stored code while `oe_n` is 0.
- R10: With `DEBOUNCE_CYCLES` = 0, a key is reported on the cycle after it is captured, with no debounce wait.
- R11: A synchronous `rst` clears `dav` and the stored code and selects column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_step | input | 1 | Strobe that moves the scan to the next column |
| row_n | input | ROWS | Row lines from the matrix; idle high, low when a closed switch meets the selected column |
| oe_n | input | 1 | Active-low enable for the data bus drivers |
| col_n | output | 4 | Column lines, one low at a time |
| dav | output | 1 | High while an accepted key stays held |
| key_bus | output | CODE_W | Stored key code, high-impedance unless `oe_n` is 0 |

## Verification
A wrong internal state appears at the ports within a few cycles. A scan counter that fails to freeze makes `col_n` move while `dav` is high. A lost row lock lets a second key change the code during a hold. A timer that is missing or too short raises `dav` earlier than the debounce or release windows allow. A wrong code shows on `key_bus` in the cycle after `dav` rises. The bench models the switch grid against `col_n`. It measures the delay from press to `dav` and from release to `dav`, and checks the code for keys in every row, including the fifth.

// File: rtl/key_matrix_encoder.sv
module key_matrix_encoder #(
  parameter int ROWS = 5,
  parameter int DEBOUNCE_CYCLES = 16,
  localparam int ROW_W = (ROWS > 4) ? 3 : 2,
  localparam int CODE_W = ROW_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_step,
  input  logic [ROWS-1:0]   row_n,
  input  logic              oe_n,
  output logic [3:0]        col_n,
  output logic              dav,
  output logic [CODE_W-1:0] key_bus
);
  localparam int TMR_W = (DEBOUNCE_CYCLES < 2) ? 1 : $clog2(DEBOUNCE_CYCLES + 1);

  typedef enum logic [1:0] {S_SCAN, S_BOUNCE, S_HELD, S_RELEASE} state_t;

  state_t              st_q;
  logic [ROWS-1:0]     rs1, rs2;
  logic [1:0]          col_q, settle_q;
  logic [ROW_W-1:0]    row_q, low_idx;
  logic [TMR_W-1:0]    tmr_q;
  logic [CODE_W-1:0]   code_q;
  logic                dav_q, any_low, row_hi, tmr_done;

  always_comb begin
    low_idx = '0;
    for (int r = ROWS - 1; r >= 0; r--)
      if (!rs2[r]) low_idx = ROW_W'(r);
  end

  assign any_low  = ~&rs2;
  assign row_hi   = rs2[row_q];
  assign tmr_done = (tmr_q == TMR_W'(DEBOUNCE_CYCLES));
  assign col_n    = ~(4'b0001 << col_q);
  assign dav      = dav_q;
  assign key_bus  = oe_n ? {CODE_W{1'bz}} : code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_SCAN;
      rs1      <= '1;
      rs2      <= '1;
      col_q    <= '0;
      settle_q <= 2'd2;
      row_q    <= '0;
      tmr_q    <= '0;
      code_q   <= '0;
      dav_q    <= 1'b0;
    end else begin
      rs1 <= row_n;
      rs2 <= rs1;
      case (st_q)
        S_SCAN:
          if (settle_q == 2'd0 && any_low) begin
            row_q <= low_idx;
            tmr_q <= '0;
            st_q  <= S_BOUNCE;
          end else if (scan_step) begin
            col_q    <= col_q + 2'd1;
            settle_q <= 2'd2;
          end else if (settle_q != 2'd0) begin
            settle_q <= settle_q - 2'd1;
          end
        S_BOUNCE:
          if (row_hi) st_q <= S_SCAN;
          else if (tmr_done) begin
            code_q <= {row_q, col_q};
            dav_q  <= 1'b1;
            st_q   <= S_HELD;
          end else tmr_q <= tmr_q + 1'b1;
        S_HELD:
          if (row_hi) begin
            dav_q <= 1'b0;
            tmr_q <= '0;
            st_q  <= S_RELEASE;
          end
        default:
          if (!row_hi) tmr_q <= '0;
          else if (tmr_done) st_q <= S_SCAN;
          else tmr_q <= tmr_q + 1'b1;
      endcase
    end
  end

  p_one_col_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(~col_n) == 1);

  p_frozen_col_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q != S_SCAN) |=> $stable(col_n));

  p_dav_after_timer_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(dav_q) |-> ($past(st_q) == S_BOUNCE && !$past(row_hi)));

  p_dav_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(dav_q)) |-> $past(row_hi));

  p_resume_after_release_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(st_q) == S_RELEASE && st_q == S_SCAN) |-> $past(row_hi));

  p_keep_code_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$rose(dav_q)) |-> $stable(code_q));
endmodule

// File: tb/key_matrix_encoder_test.sv
module key_matrix_encoder_test;
  localparam int DEB = 16;
  localparam int W = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst = 1'b1;
  logic       oe_n = 1'b0;
  logic [1:0] ph = 2'd0;
  logic       scan_step;
  logic [4:0][3:0] pressed = '0;
  logic [4:0] row_n, row_n0;
  logic [3:0] col_n, col_n0;
  logic       dav, dav0;
  wire  [W-1:0] key_bus, key_bus0;

  always @(posedge clk) ph <= ph + 2'd1;
  assign scan_step = (ph == 2'd3);

  always_comb begin
    row_n = '1;
    for (int r = 0; r < 5; r++)
      for (int c = 0; c < 4; c++)
        if (pressed[r][c] && col_n[c] == 1'b0) row_n[r] = 1'b0;
  end

  always_comb begin
    row_n0 = '1;
    for (int r = 0; r < 5; r++)
      for (int c = 0; c < 4; c++)
        if (pressed[r][c] && col_n0[c] == 1'b0) row_n0[r] = 1'b0;
  end

  key_matrix_encoder #(.ROWS(5), .DEBOUNCE_CYCLES(DEB)) uut (
    .clk(clk), .rst(rst), .scan_step(scan_step), .row_n(row_n), .oe_n(oe_n),
    .col_n(col_n), .dav(dav), .key_bus(key_bus));

  key_matrix_encoder #(.ROWS(5), .DEBOUNCE_CYCLES(0)) uut_nodb (
    .clk(clk), .rst(rst), .scan_step(scan_step), .row_n(row_n0), .oe_n(oe_n),
    .col_n(col_n0), .dav(dav0), .key_bus(key_bus0));

  // row[9:7], col[6:5], expected code[4:0] = row*4+col
  localparam logic [9:0] VEC [8] = '{
    {3'd0, 2'd0, 5'd0},  {3'd0, 2'd3, 5'd3},  {3'd1, 2'd0, 5'd4},  {3'd2, 2'd1, 5'd9},
    {3'd3, 2'd2, 5'd14}, {3'd3, 2'd3, 5'd15}, {3'd4, 2'd0, 5'd16}, {3'd4, 2'd3, 5'd19}};

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_dav(input bit nodb, input logic level, input int lim, output int n);
    n = 0;
    while (((nodb ? dav0 : dav) !== level) && n < lim) begin
      tick(1);
      n++;
    end
  endtask

  function automatic int col_idx(input logic [3:0] c);
    for (int k = 0; k < 4; k++) if (c[k] == 1'b0) return k;
    return -1;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, n0, prev, cur;
    bit seen;
    tick(3);
    // R11 reset state
    chk(col_n == 4'b1110, "R11 col", int'(col_n), 14);
    chk(dav == 1'b0, "R11 dav", int'(dav), 0);
    chk(key_bus === 5'd0, "R11 code", int'(key_bus), 0);
    rst = 1'b0;

    // R1 column sequence
    prev = col_idx(col_n);
    for (int i = 0; i < 8; i++) begin
      n = 0;
      while (col_idx(col_n) == prev && n < 10) begin tick(1); n++; end
      cur = col_idx(col_n);
      chk($countones(~col_n) == 1, "R1 onehot", int'(col_n), 0);
      chk(cur == (prev + 1) % 4, "R1 order", cur, (prev + 1) % 4);
      prev = cur;
    end

    // R3 / R5 / R8 / R10 table walk
    for (int i = 0; i < 8; i++) begin
      int r, c, code;
      r = int'(VEC[i][9:7]);
      c = int'(VEC[i][6:5]);
      code = int'(VEC[i][4:0]);
      pressed[r][c] = 1'b1;
      wait_dav(1'b0, 1'b1, 300, n);
      chk(dav == 1'b1, "R5 accepted", int'(dav), 1);
      chk(n >= DEB, "R5 delay", n, DEB);
      chk(key_bus === W'(code), "R3 code", int'(key_bus), code);
      chk(key_bus0 === W'(code), "R10 code", int'(key_bus0), code);
      pressed = '0;
      wait_dav(1'b0, 1'b0, 20, n);
      wait_dav(1'b1, 1'b0, 20, n0);
      tick(2 * DEB + 40);
      chk(key_bus === W'(code), "R8 kept", int'(key_bus), code);
    end

    // R4 lowest row wins, R2 column frozen
    pressed[1][3] = 1'b1;
    pressed[3][3] = 1'b1;
    wait_dav(1'b0, 1'b1, 300, n);
    chk(key_bus === 5'd7, "R4 priority", int'(key_bus), 7);
    tick(20);
    chk(col_n == 4'b0111, "R2 frozen", int'(col_n), 7);
    chk(dav == 1'b1, "R2 held", int'(dav), 1);
    pressed = '0;
    tick(2 * DEB + 40);

    // R10 no-debounce latency
    pressed[2][2] = 1'b1;
    wait_dav(1'b1, 1'b1, 100, n0);
    chk(n0 <= 24, "R10 latency", n0, 24);
    chk(dav == 1'b0, "R10 debounced unit still waiting", int'(dav), 0);
    chk(key_bus0 === 5'd10, "R10 code", int'(key_bus0), 10);
    wait_dav(1'b0, 1'b1, 300, n);
    pressed = '0;
    tick(2 * DEB + 40);

    // R5 bounce rejection
    seen = 1'b0;
    for (int i = 0; i < 12; i++) begin
      pressed[0][1] = 1'b1;
      for (int k = 0; k < 6; k++) begin tick(1); if (dav) seen = 1'b1; end
      pressed[0][1] = 1'b0;
      for (int k = 0; k < 2; k++) begin tick(1); if (dav) seen = 1'b1; end
    end
    chk(!seen, "R5 bounce", int'(seen), 0);
    pressed[0][1] = 1'b1;
    wait_dav(1'b0, 1'b1, 300, n);
    chk(n >= DEB, "R5 steady", n, DEB);
    chk(key_bus === 5'd1, "R5 code", int'(key_bus), 1);
    pressed = '0;
    tick(2 * DEB + 40);

    // R6 / R7 roll-over
    pressed[0][0] = 1'b1;
    wait_dav(1'b0, 1'b1, 300, n);
    pressed[1][2] = 1'b1;
    tick(30);
    chk(dav == 1'b1 && key_bus === 5'd0, "R2 lockout", int'(key_bus), 0);
    pressed[0][0] = 1'b0;
    tick(4);
    chk(dav == 1'b0, "R6 drop", int'(dav), 0);
    tick(2 * DEB - 2);
    chk(dav == 1'b0, "R7 release wait", int'(dav), 0);
    wait_dav(1'b0, 1'b1, 300, n);
    chk(dav == 1'b1, "R7 second key", int'(dav), 1);
    chk(key_bus === 5'd6, "R7 code", int'(key_bus), 6);
    pressed = '0;
    tick(2 * DEB + 40);

    // R9 tri-state
    oe_n = 1'b1;
    tick(1);
    chk(key_bus === 5'bzzzzz, "R9 hiz", int'(key_bus), 0);
    oe_n = 1'b0;
    tick(1);
    chk(key_bus === 5'd6, "R9 drive", int'(key_bus), 6);

    // R11 mid-run reset
    pressed[3][1] = 1'b1;
    wait_dav(1'b0, 1'b1, 300, n);
    pressed = '0;
    rst = 1'b1;
    tick(2);
    chk(dav == 1'b0, "R11 dav", int'(dav), 0);
    chk(key_bus === 5'd0, "R11 code", int'(key_bus), 0);
    chk(col_n == 4'b1110, "R11 col", int'(col_n), 14);
    rst = 1'b0;
    tick(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule